// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset requests into one CPU reset: a core power-on reset, a precision power-on reset, an external reset and a watchdog reset. Its sequencing logic runs on a free-running slow clock of about 32 kHz. For each source it chooses how long the register reset is held and how many slow-clock cycles the CPU reset is stretched afterwards. It also decides whether the high-frequency oscillator stays off during the sequence and how the sticky reset-cause flags change. The core power-on reset acts asynchronously and also gates the slow clock. The precision, external and watchdog requests are level inputs that are sampled on the slow clock.

When several requests are present together, the highest-priority one wins. If a new request arrives while a stretch or a low-power wait is in progress, the sequence starts again with the new source's settings. The final CPU reset is asserted asynchronously. Its release passes through a two-stage synchronizer in the CPU clock domain.

Top module: `rst_sequencer`

## Requirements
- R1: After its source ends, the CPU reset stays asserted for a per-source number of slow-clock cycles: 512 for core power-on (following the low-power wait), 1 for precision power-on, 8 for external, and 1 for watchdog.
- R2: The register reset output is high for as long as a power-on or external request is held. For a watchdog request it is high for exactly one slow-clock cycle after the request's rising edge, however long the request stays high.
- R3: The high-frequency oscillator enable is low while a power-on or external request is in effect. It stays high throughout a watchdog sequence.
- R4: After the core power-on reset ends, the oscillator enable stays low for a further 2048 slow-clock cycles (the low-power wait) before the stretch count begins.
- R5: The oscillator enable is high for at least one full slow-clock cycle before the CPU reset is released.
- R6: A power-on or external reset sets the power-on flag and clears the watchdog flag, and it pulses the RAM-lock clear output while the register reset is held. A watchdog reset sets the watchdog flag, clears the power-on flag and leaves the RAM-lock clear output low.
- R7: The reference (bandgap) enable is high at all times, during and after every reset.
- R8: The trim-register reset follows the register reset for every source except the precision power-on reset, during which it stays low.
- R9: The slow-clock enable is low only while the core power-on reset input is high.
- R10: The CPU reset rises asynchronously with the internal hold and falls on the second CPU clock edge after the hold is released.
- R11: Simultaneous requests resolve in the order core power-on, precision power-on, external, watchdog. The winner alone sets the flags and the stretch length.
- R12: A request arriving during a stretch or the low-power wait restarts the sequence with the new source's hold, wait and stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Free-running slow clock (about 32 kHz) |
| clk_cpu | input | 1 | CPU clock used for the release synchronizer |
| por_core | input | 1 | Core power-on reset, active high, asynchronous |
| por_fine | input | 1 | Precision power-on reset request, active high |
| ext_rst | input | 1 | External reset request, active high |
| wdog_rst | input | 1 | Watchdog reset request; the rising edge triggers |
| reg_rst | output | 1 | System register reset |
| trim_rst | output | 1 | Reset for the bandgap trim register |
| ram_lock_clr | output | 1 | Clears the RAM-disable control |
| cpu_rst | output | 1 | CPU reset, synchronized to clk_cpu on release |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| ref_en | output | 1 | Bandgap reference enable |
| lf_clk_en | output | 1 | Slow-clock oscillator enable |
| flag_por | output | 1 | Sticky flag: last reset was a power-on or external reset |
| flag_wdog | output | 1 | Sticky flag: last reset was a watchdog reset |

## Verification
The slow-domain outputs change one slow-clock edge after a request is sampled. The CPU reset then falls two CPU clock edges after the slow-domain release. The bench drives the inputs on falling slow-clock edges and samples on later falling edges. The fast clock's edges are offset from the slow clock's edges, and a slow half-period is two fast periods, so the synchronized release has always settled before the next sample. Expected release indices are computed as hold length plus wait plus stretch plus one. The bench checks every falling edge of each sequence against that count.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int CORE_HOLD = 512,
  parameter int FINE_HOLD = 1,
  parameter int EXT_HOLD  = 8,
  parameter int WDOG_HOLD = 1,
  parameter int LP_WAIT   = 2048
) (
  input  logic clk_slow,
  input  logic clk_cpu,
  input  logic por_core,
  input  logic por_fine,
  input  logic ext_rst,
  input  logic wdog_rst,
  output logic reg_rst,
  output logic trim_rst,
  output logic ram_lock_clr,
  output logic cpu_rst,
  output logic hf_osc_en,
  output logic ref_en,
  output logic lf_clk_en,
  output logic flag_por,
  output logic flag_wdog
);
  localparam int M1 = (LP_WAIT > CORE_HOLD) ? LP_WAIT : CORE_HOLD;
  localparam int M2 = (EXT_HOLD > FINE_HOLD) ? EXT_HOLD : FINE_HOLD;
  localparam int M3 = (M2 > WDOG_HOLD) ? M2 : WDOG_HOLD;
  localparam int MAXV = (M1 > M3) ? M1 : M3;
  localparam int CW = $clog2(MAXV + 1);

  typedef enum logic [1:0] {S_HOLD, S_LPWAIT, S_COUNT, S_RUN} state_t;
  typedef enum logic [1:0] {SRC_CORE, SRC_FINE, SRC_EXT, SRC_WDOG} src_t;

  state_t state, state_d;
  src_t src, src_d;
  logic [CW-1:0] cnt, cnt_d;
  logic wdog_q, hold;
  logic [1:0] sync;

  wire wdog_edge = wdog_rst & ~wdog_q;

  function automatic logic [CW-1:0] stretch(input src_t s);
    case (s)
      SRC_CORE: return CW'(CORE_HOLD - 1);
      SRC_FINE: return CW'(FINE_HOLD - 1);
      SRC_EXT:  return CW'(EXT_HOLD - 1);
      default:  return CW'(WDOG_HOLD - 1);
    endcase
  endfunction

  always_comb begin
    state_d = state;
    src_d   = src;
    cnt_d   = cnt;
    if (por_fine) begin
      state_d = S_HOLD;
      src_d   = SRC_FINE;
    end else if (ext_rst) begin
      state_d = S_HOLD;
      src_d   = SRC_EXT;
    end else if (wdog_edge) begin
      state_d = S_HOLD;
      src_d   = SRC_WDOG;
    end else begin
      case (state)
        S_HOLD:
          if (src == SRC_CORE) begin
            state_d = S_LPWAIT;
            cnt_d   = CW'(LP_WAIT - 1);
          end else begin
            state_d = S_COUNT;
            cnt_d   = stretch(src);
          end
        S_LPWAIT:
          if (cnt == '0) begin
            state_d = S_COUNT;
            cnt_d   = stretch(SRC_CORE);
          end else begin
            cnt_d = cnt - 1'b1;
          end
        S_COUNT:
          if (cnt == '0) state_d = S_RUN;
          else cnt_d = cnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_slow or posedge por_core) begin
    if (por_core) begin
      state     <= S_HOLD;
      src       <= SRC_CORE;
      cnt       <= '0;
      wdog_q    <= 1'b0;
      hold      <= 1'b1;
      flag_por  <= 1'b1;
      flag_wdog <= 1'b0;
    end else begin
      state  <= state_d;
      src    <= src_d;
      cnt    <= cnt_d;
      wdog_q <= wdog_rst;
      hold   <= (state_d != S_RUN);
      if (por_fine || ext_rst) begin
        flag_por  <= 1'b1;
        flag_wdog <= 1'b0;
      end else if (wdog_edge) begin
        flag_por  <= 1'b0;
        flag_wdog <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_cpu or posedge hold) begin
    if (hold) sync <= 2'b11;
    else      sync <= {sync[0], 1'b0};
  end

  assign cpu_rst      = sync[1];
  assign reg_rst      = (state == S_HOLD);
  assign trim_rst     = reg_rst && (src != SRC_FINE);
  assign ram_lock_clr = reg_rst && (src != SRC_WDOG);
  assign hf_osc_en    = !((state == S_LPWAIT) || (state == S_HOLD && src != SRC_WDOG));
  assign ref_en       = 1'b1;
  assign lf_clk_en    = ~por_core;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
  input logic clk_slow,
  input logic clk_cpu,
  input logic por_core,
  input logic por_fine,
  input logic ext_rst,
  input logic wdog_rst,
  input logic reg_rst,
  input logic trim_rst,
  input logic hf_osc_en,
  input logic cpu_rst,
  input logic flag_por,
  input logic flag_wdog,
  input logic hold
);
  // R3
  osc_off_hold_chk: assert property (@(posedge clk_slow) disable iff (por_core)
    (por_fine || ext_rst) |=> !hf_osc_en);

  // R8
  trim_keep_chk: assert property (@(posedge clk_slow) disable iff (por_core)
    por_fine |=> (reg_rst && !trim_rst));

  // R2
  ext_hold_chk: assert property (@(posedge clk_slow) disable iff (por_core)
    (ext_rst && !por_fine) |=> (reg_rst && flag_por && !flag_wdog));

  // R6
  wdog_flag_chk: assert property (@(posedge clk_slow) disable iff (por_core)
    (wdog_rst && !$past(wdog_rst) && !$past(por_core) && !por_fine && !ext_rst)
      |=> (flag_wdog && !flag_por && reg_rst));

  // R5
  osc_lead_chk: assert property (@(posedge clk_slow) disable iff (por_core)
    $fell(hold) |-> ($past(hf_osc_en) && hf_osc_en));

  // R10
  cpu_sync_chk: assert property (@(posedge clk_cpu) disable iff (por_core)
    hold |=> cpu_rst);
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
  .clk_slow(clk_slow), .clk_cpu(clk_cpu), .por_core(por_core),
  .por_fine(por_fine), .ext_rst(ext_rst), .wdog_rst(wdog_rst),
  .reg_rst(reg_rst), .trim_rst(trim_rst), .hf_osc_en(hf_osc_en),
  .cpu_rst(cpu_rst), .flag_por(flag_por), .flag_wdog(flag_wdog),
  .hold(hold)
);

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
  localparam int LP = 2048;

  logic clk = 1'b0;
  logic clk_slow = 1'b0;
  logic por_core = 1'b0, por_fine = 1'b0, ext_rst = 1'b0, wdog_rst = 1'b0;
  logic reg_rst, trim_rst, ram_lock_clr, cpu_rst, hf_osc_en, ref_en, lf_clk_en;
  logic flag_por, flag_wdog;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #20 clk_slow = ~clk_slow;
  end

  rst_sequencer uut (
    .clk_slow(clk_slow), .clk_cpu(clk), .por_core(por_core), .por_fine(por_fine),
    .ext_rst(ext_rst), .wdog_rst(wdog_rst), .reg_rst(reg_rst), .trim_rst(trim_rst),
    .ram_lock_clr(ram_lock_clr), .cpu_rst(cpu_rst), .hf_osc_en(hf_osc_en),
    .ref_en(ref_en), .lf_clk_en(lf_clk_en), .flag_por(flag_por), .flag_wdog(flag_wdog)
  );

  // source codes: 0 core power-on, 1 precision power-on, 2 external, 3 watchdog
  function automatic int n_of(input int s);
    case (s)
      0: return 512;
      1: return 1;
      2: return 8;
      default: return 1;
    endcase
  endfunction
  function automatic int exp_hold(input int s, input int h);
    return (s == 3) ? 1 : h;
  endfunction
  function automatic int exp_rel(input int s, input int h);
    return exp_hold(s, h) + n_of(s) + ((s == 0) ? LP : 0) + 1;
  endfunction
  function automatic int osc_off(input int s, input int h);
    return (s == 3) ? 0 : ((s == 0) ? h + LP : h);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  task automatic drop_all();
    por_core = 1'b0; por_fine = 1'b0; ext_rst = 1'b0; wdog_rst = 1'b0;
  endtask

  // mask bits: [0] core, [1] precision, [2] external, [3] watchdog
  task automatic run_seq(input logic [3:0] mask, input int h, input int win,
                         input int limit, input string tag);
    int hn, rel, off, last;
    hn  = exp_hold(win, h);
    rel = exp_rel(win, h);
    off = osc_off(win, h);
    last = (limit > 0 && limit < rel) ? limit : rel;
    @(negedge clk_slow);
    if (mask[0]) por_core = 1'b1;
    if (mask[1]) por_fine = 1'b1;
    if (mask[2]) ext_rst  = 1'b1;
    if (mask[3]) wdog_rst = 1'b1;
    for (int i = 1; i <= last; i++) begin
      @(negedge clk_slow);
      chk({tag, " R1 R10 cpu_rst"}, cpu_rst, (i < rel) ? 1 : 0);
      chk({tag, " R2 reg_rst"}, reg_rst, (i <= hn) ? 1 : 0);
      chk({tag, (i <= hn) ? " R3 osc" : ((i <= off) ? " R4 osc" : " R5 osc")},
          hf_osc_en, (i <= off) ? 0 : 1);
      chk({tag, " R8 trim_rst"}, trim_rst, (i <= hn && win != 1) ? 1 : 0);
      chk({tag, " R6 ram_lock_clr"}, ram_lock_clr, (i <= hn && win != 3) ? 1 : 0);
      chk({tag, " R9 lf_clk_en"}, lf_clk_en, (mask[0] && i <= h) ? 0 : 1);
      chk({tag, " R7 ref_en"}, ref_en, 1);
      if (i == h) drop_all();
    end
    drop_all();
    if (limit == 0) begin
      chk({tag, " R6 flag_por"}, flag_por, (win != 3) ? 1 : 0);
      chk({tag, " R6 flag_wdog"}, flag_wdog, (win == 3) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #1 por_core = 1'b1;
    @(negedge clk_slow);
    chk("reset R2 reg_rst", reg_rst, 1);
    chk("reset R10 cpu_rst", cpu_rst, 1);
    chk("reset R3 osc", hf_osc_en, 0);
    chk("reset R9 lf_clk_en", lf_clk_en, 0);
    chk("reset R6 flag_por", flag_por, 1);
    chk("reset R6 flag_wdog", flag_wdog, 0);
    chk("reset R7 ref_en", ref_en, 1);

    run_seq(4'b0001, 3, 0, 0, "core");
    run_seq(4'b0010, 2, 1, 0, "fine");
    run_seq(4'b0100, 5, 2, 0, "ext");
    run_seq(4'b1000, 1, 3, 0, "wdog");
    run_seq(4'b1000, 5, 3, 0, "wdog long");
    run_seq(4'b0100, 1, 2, 0, "ext after wdog");

    run_seq(4'b0110, 4, 1, 0, "R11 fine+ext");
    run_seq(4'b1100, 3, 2, 0, "R11 ext+wdog");

    run_seq(4'b0001, 2, 0, 10, "R12 core wait");
    run_seq(4'b0100, 3, 2, 0, "R12 ext restart");
    run_seq(4'b0001, 2, 0, 100, "R12 core wait");
    run_seq(4'b1000, 1, 3, 0, "R12 wdog restart");
    run_seq(4'b0100, 2, 2, 5, "R12 ext count");
    run_seq(4'b0010, 3, 1, 0, "R12 fine restart");

    for (int k = 0; k < 30; k++) begin
      int r, s, h, gap;
      r = $urandom_range(0, 7);
      s = (r == 0) ? 0 : (r <= 2) ? 1 : (r <= 4) ? 2 : 3;
      h = $urandom_range(1, 6);
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_slow);
        chk("rand idle R1 cpu_rst", cpu_rst, 0);
      end
      run_seq(4'(1 << s), h, s, 0, "rand");
    end

    summary();
    $finish;
  end
endmodule